// File: doc/BRIEF.md
# Power Domain Slice Sequencer

This block powers a single switchable logic slice off and back on. Power-down takes four steps: a security handshake request, isolation on, reset assert and power switch off. Power-up takes the same four steps in reverse. The block moves to the next step only after the status input of the current step reaches its target value. The step reached is held as a level from 0 (slice fully on) to 4 (slice fully off). The sequencer steps that level one place at a time toward a target level.

Three things can set the target level. A single power-down request bit asks for the whole series. Four manual step bits allow stepping one action at a time. A per-domain low-power level table sets the target when it is compared against the current low-power modes of 16 requesting domains. The block has a small word-wide register interface for the control bits, the level table and a read-only status word. The request outputs go to the slice's handshake, isolation, reset and power switch. The matching acknowledge inputs come back from them.

Top module: `pds_top`

## Requirements
- R1: After reset, all four request outputs are 0 (switch on, isolation off, reset released, handshake idle), `seq_busy` is 0, and every register reads 0. A control value of 0 selects software mode.
- R2: On the way down, the requests are raised in this order: `hsk_req`, `iso_req`, `rst_req`, `psw_off_req`. A request is raised only after the previous step has been confirmed: `hsk_stat`=1, `iso_stat`=1, `rst_stat`=0.
- R3: On the way up, the requests are dropped in this order: `psw_off_req`, `rst_req`, `iso_req`, `hsk_req`. A request is dropped only after the later step has been confirmed: `psw_stat`=0, `rst_stat`=1, `iso_stat`=0.
- R4: While the status input of the current step has not reached its target, the request outputs hold. Each step changes exactly one request.
- R5: Control register (address 0) bits [3:0] are the manual step bits: handshake, isolation, reset and switch-off. In software mode with bit 4 clear, the target level is one plus the index of the highest set step bit, or 0 if no step bit is set. The fixed order is therefore kept even when a later bit is set alone.
- R6: Control bit 4 is the power-down request. When it is set in software mode, the target level is 4 (full off series). When it is cleared and no step bit is set, the target level is 0 (full on series).
- R7: Control bit 8 selects low-power mode. In that mode the step bits and the request bit have no effect.
- R8: The 4-bit level of domain n sits in register 1 + n/8, at bits 4*(n mod 8)+3 down to 4*(n mod 8). Domain n's current mode is `dom_mode` bits 4n+3 down to 4n.
- R9: In low-power mode, a domain needs the slice on when its mode is below its level. The target level is 4 only when no domain needs the slice on, and 0 otherwise.
- R10: The status register (address 3) shows the current level in bits [2:0] and the busy flag in bit 4. A target change that arrives while a step is waiting is not acted on until that step is confirmed.
- R11: Registers 0 to 2 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| dom_mode | input | 64 | Current low-power mode of each of 16 domains, 4 bits each |
| hsk_req | output | 1 | Security handshake request |
| iso_req | output | 1 | Isolation enable |
| rst_req | output | 1 | Slice reset assert |
| psw_off_req | output | 1 | Power switch off |
| hsk_stat | input | 1 | 1 while the handshake is active |
| iso_stat | input | 1 | 1 while isolation is on |
| rst_stat | input | 1 | 0 while the slice is in reset, 1 when released |
| psw_stat | input | 1 | 1 while the switch is off |
| seq_busy | output | 1 | A step is waiting for its acknowledge |

## Verification
The bench freezes the isolation acknowledge in the middle of a power-down and then reverses the request. A design that does not gate on status, or that acts on a new target mid-step, would move the outputs or drop the handshake while isolation is still pending. Setting only the switch-off bit checks that the design still walks through the earlier steps rather than cutting power first. A monitor checks every request edge against the status seen just before it, which catches an inverted reset status or a swapped order. The low-power vectors place the deciding levels in domain 0 and domain 15, so that a wrong nibble packing or an inverted comparison flips the slice state.

// File: rtl/pds_pkg.sv
package pds_pkg;
    localparam int STEPS  = 4;
    localparam int STEP_W = $clog2(STEPS);
    localparam int LVL_W  = $clog2(STEPS + 1);

    typedef enum logic {SEQ_IDLE, SEQ_WAIT} seq_e;

    typedef struct packed {
        seq_e              st;
        logic              dir_up;
        logic [STEP_W-1:0] stp;
        logic [LVL_W-1:0]  lvl;
        logic [STEPS-1:0]  req;
    } seq_s;
endpackage

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
#(
    parameter int NDOM = 16,
    parameter int LB   = 4,
    parameter int DW   = 32,
    parameter int AW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic [LVL_W-1:0]     stat_lvl,
    input  logic                 stat_busy,
    output logic [STEPS-1:0]     sw_bits,
    output logic                 pdn_bit,
    output logic                 lpm_sel,
    output logic [NDOM*LB-1:0]   levels
);
    localparam int NREG     = (NDOM * LB) / DW;
    localparam int STAT_ADR = NREG + 1;
    localparam int PDN_BIT  = STEPS;
    localparam int LPM_BIT  = 8;

    typedef struct packed {
        logic [STEPS-1:0]   sw;
        logic               pdn;
        logic               lpm;
        logic [NDOM*LB-1:0] lvl;
    } reg_s;

    reg_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == '0) begin
                r_d.sw  = wdata[STEPS-1:0];
                r_d.pdn = wdata[PDN_BIT];
                r_d.lpm = wdata[LPM_BIT];
            end
            for (int k = 0; k < NREG; k++) begin
                if (int'(addr) == k + 1) r_d.lvl[k*DW +: DW] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata[STEPS-1:0] = r_q.sw;
            rdata[PDN_BIT]   = r_q.pdn;
            rdata[LPM_BIT]   = r_q.lpm;
        end
        for (int k = 0; k < NREG; k++) begin
            if (int'(addr) == k + 1) rdata = r_q.lvl[k*DW +: DW];
        end
        if (int'(addr) == STAT_ADR) begin
            rdata[LVL_W-1:0] = stat_lvl;
            rdata[4]         = stat_busy;
        end
    end

    assign sw_bits = r_q.sw;
    assign pdn_bit = r_q.pdn;
    assign lpm_sel = r_q.lpm;
    assign levels  = r_q.lvl;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> (lpm_sel == $past(wdata[LPM_BIT]))) else $error("ctrl write lost"); // R11
endmodule

// File: rtl/pds_vote.sv
module pds_vote #(
    parameter int NDOM = 16,
    parameter int LB   = 4
) (
    input  logic [NDOM*LB-1:0] levels,
    input  logic [NDOM*LB-1:0] modes,
    output logic               all_off
);
    logic [NDOM-1:0] need_on;

    for (genvar n = 0; n < NDOM; n++) begin : g_dom
        assign need_on[n] = modes[n*LB +: LB] < levels[n*LB +: LB];
    end

    assign all_off = ~|need_on;
endmodule

// File: rtl/pds_seq.sv
module pds_seq
    import pds_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tgt,
    input  logic [STEPS-1:0] done,
    output logic [STEPS-1:0] req,
    output logic [LVL_W-1:0] lvl,
    output logic             busy
);
    seq_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SEQ_IDLE: begin
                if (tgt > s_q.lvl) begin
                    s_d.req[s_q.lvl[STEP_W-1:0]] = 1'b1;
                    s_d.stp    = s_q.lvl[STEP_W-1:0];
                    s_d.dir_up = 1'b0;
                    s_d.st     = SEQ_WAIT;
                end else if (tgt < s_q.lvl) begin
                    s_d.stp    = s_q.lvl[STEP_W-1:0] - 1'b1;
                    s_d.req[s_d.stp] = 1'b0;
                    s_d.dir_up = 1'b1;
                    s_d.st     = SEQ_WAIT;
                end
            end
            default: begin
                if (done[s_q.stp] == s_q.req[s_q.stp]) begin
                    s_d.lvl = s_q.dir_up ? s_q.lvl - 1'b1 : s_q.lvl + 1'b1;
                    s_d.st  = SEQ_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign req  = s_q.req;
    assign lvl  = s_q.lvl;
    assign busy = (s_q.st == SEQ_WAIT);

    AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & (req + 1'b1)) == '0)) else $error("step order broken"); // R2
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req ^ $past(req)) <= 1)) else $error("multi-step change"); // R4
    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done[s_q.stp] != req[s_q.stp]) |=> $stable(req)) else $error("moved before ack"); // R4
    for (genvar i = 1; i < STEPS; i++) begin : g_dn
        AST_DOWN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req[i]) |-> $past(done[i-1])) else $error("down step ungated"); // R2
    end
    for (genvar i = 0; i < STEPS - 1; i++) begin : g_up
        AST_UP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(req[i]) |-> $past(!done[i+1])) else $error("up step ungated"); // R3
    end
endmodule

// File: rtl/pds_top.sv
module pds_top
    import pds_pkg::*;
#(
    parameter int NDOM = 16,
    parameter int LB   = 4,
    parameter int DW   = 32,
    parameter int AW   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic [NDOM*LB-1:0] dom_mode,
    output logic               hsk_req,
    output logic               iso_req,
    output logic               rst_req,
    output logic               psw_off_req,
    input  logic               hsk_stat,
    input  logic               iso_stat,
    input  logic               rst_stat,
    input  logic               psw_stat,
    output logic               seq_busy
);
    logic [STEPS-1:0]   sw_bits, done, req;
    logic               pdn_bit, lpm_sel, all_off;
    logic [NDOM*LB-1:0] levels;
    logic [LVL_W-1:0]   tgt, lvl;

    pds_regs #(.NDOM(NDOM), .LB(LB), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .stat_lvl(lvl), .stat_busy(seq_busy), .sw_bits(sw_bits),
        .pdn_bit(pdn_bit), .lpm_sel(lpm_sel), .levels(levels)
    );

    pds_vote #(.NDOM(NDOM), .LB(LB)) u_vote (
        .levels(levels), .modes(dom_mode), .all_off(all_off)
    );

    always_comb begin
        tgt = '0;
        if (lpm_sel) begin
            tgt = all_off ? LVL_W'(STEPS) : '0;
        end else if (pdn_bit) begin
            tgt = LVL_W'(STEPS);
        end else begin
            for (int i = 0; i < STEPS; i++) begin
                if (sw_bits[i]) tgt = LVL_W'(i + 1);
            end
        end
    end

    // status normalised to "step applied" polarity
    assign done = {psw_stat, ~rst_stat, iso_stat, hsk_stat};

    pds_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tgt(tgt), .done(done),
        .req(req), .lvl(lvl), .busy(seq_busy)
    );

    assign hsk_req     = req[0];
    assign iso_req     = req[1];
    assign rst_req     = req[2];
    assign psw_off_req = req[3];

    AST_LPM_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_sel && !all_off) |-> (tgt == '0)) else $error("domain needs slice on"); // R9
endmodule

// File: tb/sim_pds_top.sv
module sim_pds_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] dom_mode = '0;
    logic        hsk_req, iso_req, rst_req, psw_off_req, seq_busy;
    logic        hsk_stat = 1'b0, iso_stat = 1'b0, rst_stat = 1'b1, psw_stat = 1'b0;
    logic [3:0]  freeze = '0;
    int          cnt [4];
    int          n_chk = 0, n_bad = 0, viol = 0, cyc = 0;

    always #2 clk = ~clk;

    pds_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dom_mode(dom_mode), .hsk_req(hsk_req), .iso_req(iso_req),
        .rst_req(rst_req), .psw_off_req(psw_off_req), .hsk_stat(hsk_stat),
        .iso_stat(iso_stat), .rst_stat(rst_stat), .psw_stat(psw_stat), .seq_busy(seq_busy)
    );

    // slice model and order monitor
    logic [3:0] prev_req = '0;
    always @(negedge clk) begin
        logic [3:0] r, st;
        r  = {psw_off_req, rst_req, iso_req, hsk_req};
        st = {psw_stat, ~rst_stat, iso_stat, hsk_stat};
        if (r[1] && !prev_req[1] && !st[0]) viol++;
        if (r[2] && !prev_req[2] && !st[1]) viol++;
        if (r[3] && !prev_req[3] && !st[2]) viol++;
        if (!r[2] && prev_req[2] && st[3]) viol++;
        if (!r[1] && prev_req[1] && st[2]) viol++;
        if (!r[0] && prev_req[0] && st[1]) viol++;
        prev_req = r;
        for (int i = 0; i < 4; i++) begin
            if (!freeze[i] && st[i] != r[i]) begin
                cnt[i]++;
                if (cnt[i] >= 3) begin
                    st[i] = r[i];
                    cnt[i] = 0;
                end
            end else cnt[i] = 0;
        end
        hsk_stat = st[0]; iso_stat = st[1]; rst_stat = ~st[2]; psw_stat = st[3];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  a;
        logic [31:0] d;
        logic [63:0] m;
        logic [3:0]  r;
        logic [2:0]  l;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{2'd0, 32'h010, 64'h0, 4'hF, 3'd4},                 // R6 full off
        '{2'd0, 32'h000, 64'h0, 4'h0, 3'd0},                 // R6 full on
        '{2'd0, 32'h001, 64'h0, 4'h1, 3'd1},                 // R5 manual
        '{2'd0, 32'h003, 64'h0, 4'h3, 3'd2},
        '{2'd0, 32'h007, 64'h0, 4'h7, 3'd3},
        '{2'd0, 32'h00F, 64'h0, 4'hF, 3'd4},
        '{2'd0, 32'h003, 64'h0, 4'h3, 3'd2},                 // R3 partial up
        '{2'd0, 32'h008, 64'h0, 4'hF, 3'd4},                 // R5 order kept
        '{2'd0, 32'h000, 64'h0, 4'h0, 3'd0},
        '{2'd1, 32'h2,   64'h0, 4'h0, 3'd0},                 // R8 dom0 level 2
        '{2'd0, 32'h100, 64'h0, 4'h0, 3'd0},                 // R9 dom0 needs on
        '{2'd0, 32'h11F, 64'h0, 4'h0, 3'd0},                 // R7 sw bits ignored
        '{2'd2, 32'h3000_0000, 64'h2, 4'h0, 3'd0},           // R8 dom15 level 3
        '{2'd2, 32'h3000_0000, 64'h3000_0000_0000_0002, 4'hF, 3'd4}, // R9 all allow
        '{2'd2, 32'h3000_0000, 64'h3000_0000_0000_0001, 4'h0, 3'd0}, // R9 dom0 wakes
        '{2'd0, 32'h000, 64'h0, 4'h0, 3'd0}                  // R7 back to sw
    };

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 4; i++) cnt[i] = 0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 req", {28'h0, psw_off_req, rst_req, iso_req, hsk_req}, 32'h0);
        chk("R1 busy", {31'h0, seq_busy}, 32'h0);
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(2'd3, v); chk("R1 status", v, 32'h0);

        for (int k = 0; k < 16; k++) begin
            dom_mode = VEC[k].m;
            wr(VEC[k].a, VEC[k].d);
            idle(60);
            chk($sformatf("R2/R3/R5-R9 vec%0d req", k),
                {28'h0, psw_off_req, rst_req, iso_req, hsk_req}, {28'h0, VEC[k].r});
            rd(2'd3, v);
            chk($sformatf("R10 vec%0d status", k), v, {29'h0, VEC[k].l});
        end

        // R11 readback, R8 packing
        rd(2'd1, v); chk("R11 lvl reg1", v, 32'h2);
        rd(2'd2, v); chk("R11 lvl reg2", v, 32'h3000_0000);

        // R4 stall on isolation ack, R10 mid-step request waits
        freeze = 4'b0010;
        wr(2'd0, 32'h010);
        idle(30);
        chk("R4 stalled req", {28'h0, psw_off_req, rst_req, iso_req, hsk_req}, 32'h3);
        rd(2'd3, v); chk("R10 busy status", v, 32'h11);
        wr(2'd0, 32'h000);
        idle(30);
        chk("R10 held req", {28'h0, psw_off_req, rst_req, iso_req, hsk_req}, 32'h3);
        chk("R10 busy", {31'h0, seq_busy}, 32'h1);
        freeze = '0;
        idle(60);
        chk("R10 resumed up", {28'h0, psw_off_req, rst_req, iso_req, hsk_req}, 32'h0);
        rd(2'd3, v); chk("R10 final status", v, 32'h0);

        chk("R2/R3 order monitor", viol, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end
endmodule